// File: doc/BRIEF.md
# Step/direction microstep position sequencer

This block converts step and direction pulses from a motion controller into an electrical position held at a fixed resolution of 256 microsteps per full-step. The position is a 10-bit counter that covers four full-steps, which is one electrical revolution, and wraps modulo 1024. A two-bit resolution code sets how many internal microsteps each step pulse moves the counter. A build parameter chooses between two code maps. The default map is used throughout this note.

From the position, the block derives a coil current pair. Coil A follows a sine of the electrical angle and coil B follows a cosine. Both are read from one quarter-wave magnitude table by quadrant folding, and each comes with a separate sign bit. An index pulse marks each pass through electrical zero. An active-low enable input forces both coil outputs to zero drive. Step tracking continues while the coils are off, so the position is not lost.

Top module: `stepdir_seq`

## Requirements
- R1: While `rst_ni` is low, `pos_o` is 0 and `index_o`, both magnitudes and both signs are 0. After reset is released the position stays 0 until the first step.
- R2: With `MS_VARIANT`=0, the code `ms_i` (bit 1 = MS2, bit 0 = MS1) sets the microsteps moved per step: 2'b00 = 32, 2'b01 = 128, 2'b10 = 64, 2'b11 = 16. With `MS_VARIANT`=1 the same codes give 64, 32, 16 and 8.
- R3: Each accepted step adds its increment to `pos_o` when `dir_i`=1 and subtracts it when `dir_i`=0, modulo 1024. The position updates three clock edges after `step_i` rises.
- R4: Only a rising edge of `step_i` is a step. Holding `step_i` high, or keeping it low, leaves `pos_o` unchanged.
- R5: `index_o` is high for exactly one cycle, together with the new position, in two cases: an upward step that wraps past 1023, or a downward step from a nonzero position that reaches or passes 0. A downward step that leaves position 0 does not pulse the index.
- R6: Let q = pos[9:8] and p = pos[7:0]. Set k = p for even q and k = 256-p for odd q, and m(k) = floor(k*(512-k)*255/65536). Then `coil_a_mag_o` = m(k) and `coil_a_neg_o` = pos[9]. Both are registered one cycle after the position.
- R7: Coil B is computed the same way as R6, using the position plus 256 (mod 1024).
- R8: If `en_ni` was high at the previous clock edge, both magnitudes and both signs are 0. Steps received while `en_ni` is high still update `pos_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step pulse input; a rising edge is one step |
| dir_i | input | 1 | Direction: 1 counts up, 0 counts down |
| ms_i | input | 2 | Resolution code, {MS2, MS1} |
| en_ni | input | 1 | Driver enable, active low |
| pos_o | output | 10 | Electrical microstep position |
| index_o | output | 1 | One-cycle pulse at electrical zero |
| coil_a_mag_o | output | 8 | Coil A current magnitude |
| coil_a_neg_o | output | 1 | Coil A current sign, 1 = negative |
| coil_b_mag_o | output | 8 | Coil B current magnitude |
| coil_b_neg_o | output | 1 | Coil B current sign, 1 = negative |

## Verification
The bench runs a full electrical revolution upward and then downward with each of the four resolution codes.
- Checking position and both coils after every step covers every quadrant fold, every sign change and the peak entry of the table for each step size. Errors in the increment map, the fold direction or the B-coil phase each show up as distinct mismatches.
- Counting index pulses per step separates a real zero arrival from wraps in the wrong direction.
- A code change that leaves the position off the new step grid makes a downward step jump across zero without landing on it. A step down from zero is also tried.
- A long-held step level and a disabled driver confirm that only rising edges move the position and that tracking continues with the coils off.

// File: rtl/stepdir_pkg.sv
package stepdir_pkg;
  localparam int unsigned USTEP_PER_FULL = 256;
  localparam int unsigned FULL_PER_REV   = 4;
  localparam int unsigned POS_W = $clog2(USTEP_PER_FULL * FULL_PER_REV);
  localparam int unsigned QTR_W = $clog2(USTEP_PER_FULL);

  // microsteps per step for a resolution code under a given pin map
  function automatic logic [POS_W-1:0] step_inc(input int variant, input logic [1:0] code);
    logic [POS_W-1:0] r;
    if (variant == 0) begin
      unique case (code)
        2'b00: r = POS_W'(USTEP_PER_FULL / 8);
        2'b01: r = POS_W'(USTEP_PER_FULL / 2);
        2'b10: r = POS_W'(USTEP_PER_FULL / 4);
        default: r = POS_W'(USTEP_PER_FULL / 16);
      endcase
    end else begin
      unique case (code)
        2'b00: r = POS_W'(USTEP_PER_FULL / 4);
        2'b01: r = POS_W'(USTEP_PER_FULL / 8);
        2'b10: r = POS_W'(USTEP_PER_FULL / 16);
        default: r = POS_W'(USTEP_PER_FULL / 32);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/stepdir_sync.sv
module stepdir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= raw_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4
  rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/stepdir_pos.sv
module stepdir_pos
  import stepdir_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [POS_W-1:0] inc_i,
  output logic [POS_W-1:0] pos_o,
  output logic             index_o
);
  logic [POS_W:0]   sum_up;
  logic [POS_W-1:0] diff_dn;
  logic             wrap_up, hit_dn;

  assign sum_up  = {1'b0, pos_o} + {1'b0, inc_i};
  assign diff_dn = pos_o - inc_i;
  assign wrap_up = sum_up[POS_W];
  // downward arrival at or across zero, never when leaving zero
  assign hit_dn  = (pos_o != '0) && (pos_o <= inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o   <= '0;
      index_o <= 1'b0;
    end else if (step_i) begin
      pos_o   <= up_i ? sum_up[POS_W-1:0] : diff_dn;
      index_o <= up_i ? wrap_up : hit_dn;
    end else begin
      index_o <= 1'b0;
    end
  end

  // R4
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_o));
  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && up_i) |=> (pos_o == POS_W'($past(pos_o) + $past(inc_i))));
  // R3
  dn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !up_i) |=> (pos_o == POS_W'($past(pos_o) - $past(inc_i))));
  // R5
  idx_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    index_o |-> $past(step_i));
  // R5
  idx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    index_o |=> !index_o);
endmodule

// File: rtl/stepdir_coil.sv
module stepdir_coil
  import stepdir_pkg::*;
#(
  parameter int unsigned AMP_W = 8,
  parameter int unsigned PHASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             off_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [AMP_W-1:0] mag_o,
  output logic             neg_o
);
  localparam int unsigned TAB_N  = USTEP_PER_FULL + 1;
  localparam int unsigned HALF   = 2 * USTEP_PER_FULL;
  localparam int unsigned AMP_MX = (1 << AMP_W) - 1;
  localparam int unsigned NORM   = USTEP_PER_FULL * USTEP_PER_FULL;

  logic [AMP_W-1:0] qtab [TAB_N];

  genvar i;
  generate
    for (i = 0; i < TAB_N; i++) begin : g_tab
      assign qtab[i] = AMP_W'((longint'(i) * longint'(HALF - i) * longint'(AMP_MX)) / longint'(NORM));
    end
  endgenerate

  logic [POS_W-1:0] ph;
  logic [1:0]       quad;
  logic [QTR_W-1:0] frac;
  logic [QTR_W:0]   k;

  assign ph   = pos_i + POS_W'(PHASE);
  assign quad = ph[POS_W-1 -: 2];
  assign frac = ph[QTR_W-1:0];
  assign k    = quad[0] ? ((QTR_W+1)'(USTEP_PER_FULL) - {1'b0, frac}) : {1'b0, frac};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o <= '0;
      neg_o <= 1'b0;
    end else if (off_i) begin
      mag_o <= '0;
      neg_o <= 1'b0;
    end else begin
      mag_o <= qtab[k];
      neg_o <= quad[1];
    end
  end

  // R8
  off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> (mag_o == '0 && !neg_o));
endmodule

// File: rtl/stepdir_seq.sv
module stepdir_seq
  import stepdir_pkg::*;
#(
  parameter int unsigned MS_VARIANT  = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AMP_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [1:0]       ms_i,
  input  logic             en_ni,
  output logic [POS_W-1:0] pos_o,
  output logic             index_o,
  output logic [AMP_W-1:0] coil_a_mag_o,
  output logic             coil_a_neg_o,
  output logic [AMP_W-1:0] coil_b_mag_o,
  output logic             coil_b_neg_o
);
  logic             step_rise;
  logic [POS_W-1:0] inc;

  assign inc = step_inc(int'(MS_VARIANT), ms_i);

  stepdir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .raw_i(step_i), .rise_o(step_rise)
  );

  stepdir_pos u_pos (
    .clk_i, .rst_ni, .step_i(step_rise), .up_i(dir_i), .inc_i(inc),
    .pos_o, .index_o
  );

  logic [AMP_W-1:0] mag [2];
  logic [1:0]       neg;

  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_coil
      stepdir_coil #(.AMP_W(AMP_W), .PHASE(c * USTEP_PER_FULL)) u_coil (
        .clk_i, .rst_ni, .off_i(en_ni), .pos_i(pos_o),
        .mag_o(mag[c]), .neg_o(neg[c])
      );
    end
  endgenerate

  assign coil_a_mag_o = mag[0];
  assign coil_a_neg_o = neg[0];
  assign coil_b_mag_o = mag[1];
  assign coil_b_neg_o = neg[1];

  // R6
  sign_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_ni) |-> (coil_a_neg_o == $past(pos_o[POS_W-1])));
  // R7
  sign_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_ni) |-> (coil_b_neg_o == $past(pos_o[POS_W-1] ^ pos_o[POS_W-2])));
  // R6
  zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pos_o[QTR_W-1:0]) == '0 && !$past(pos_o[QTR_W])) |-> (coil_a_mag_o == '0));
endmodule

// File: tb/stepdir_seq_test.sv
module stepdir_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0, dir = 1'b1, en_n = 1'b0;
  logic [1:0] ms = 2'b00;
  logic [9:0] pos;
  logic       idx, a_neg, b_neg;
  logic [7:0] a_mag, b_mag;

  int checks = 0, fails = 0, idx_cnt = 0;
  int model_pos = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stepdir_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir), .ms_i(ms), .en_ni(en_n),
    .pos_o(pos), .index_o(idx), .coil_a_mag_o(a_mag), .coil_a_neg_o(a_neg),
    .coil_b_mag_o(b_mag), .coil_b_neg_o(b_neg)
  );

  always @(negedge clk) if (idx) idx_cnt++;

  function automatic int inc_of(input logic [1:0] c);
    case (c)
      2'b00: return 32;
      2'b01: return 128;
      2'b10: return 64;
      default: return 16;
    endcase
  endfunction

  function automatic int mag_of(input int p);
    int q = (p / 256) % 4;
    int f = p % 256;
    int k = (q % 2) ? 256 - f : f;
    return (k * (512 - k) * 255) / 65536;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit up);
    dir = up;
    @(negedge clk) step = 1'b1;
    repeat (4) @(negedge clk);
    step = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input int exp_idx);
    int pb = (model_pos + 256) % 1024;
    chk("R2/R3 pos", int'(pos), model_pos);
    chk("R5 index", idx_cnt, exp_idx);
    if (!en_n) begin
      chk("R6 a_mag", int'(a_mag), mag_of(model_pos));
      chk("R6 a_neg", int'(a_neg), model_pos / 512);
      chk("R7 b_mag", int'(b_mag), mag_of(pb));
      chk("R7 b_neg", int'(b_neg), pb / 512);
    end
  endtask

  task automatic do_step(input bit up);
    int inc = inc_of(ms);
    int nxt = up ? model_pos + inc : model_pos - inc;
    int e = up ? int'(nxt >= 1024) : int'(model_pos != 0 && model_pos <= inc);
    idx_cnt = 0;
    pulse(up);
    model_pos = (nxt + 1024) % 1024;
    check_all(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1 pos in reset", int'(pos), 0);
    chk("R1 idx in reset", int'(idx), 0);
    chk("R1 coils in reset", int'({a_mag, b_mag, a_neg, b_neg}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: after reset, coil B at peak, A zero
    idx_cnt = 0;
    check_all(0);

    // R2 R3 R5 R6 R7: full revolution per code, both directions
    for (int c = 0; c < 4; c++) begin
      ms = 2'(c);
      repeat (2) @(negedge clk);
      for (int s = 0; s < 1024 / inc_of(ms); s++) do_step(1'b1);
      for (int s = 0; s < 1024 / inc_of(ms); s++) do_step(1'b0);
    end

    // R5: step down from zero gives no index
    ms = 2'b11;
    @(negedge clk);
    do_step(1'b0);
    do_step(1'b1);
    // R5: off-grid crossing downward
    do_step(1'b1);
    ms = 2'b01;
    @(negedge clk);
    do_step(1'b0);
    chk("R5 crossing pos", int'(pos), 912);

    // R4: held high and held low do not move
    dir = 1'b1;
    @(negedge clk) step = 1'b1;
    repeat (40) @(negedge clk);
    model_pos = (model_pos + 128) % 1024;
    chk("R4 held high", int'(pos), model_pos);
    step = 1'b0;
    repeat (40) @(negedge clk);
    chk("R4 held low", int'(pos), model_pos);

    // R8: disabled driver keeps tracking, coils zero
    en_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 a_mag off", int'(a_mag), 0);
    chk("R8 b_mag off", int'(b_mag), 0);
    chk("R8 signs off", int'({a_neg, b_neg}), 0);
    ms = 2'b10;
    @(negedge clk);
    do_step(1'b1);
    do_step(1'b1);
    chk("R8 b_mag still off", int'(b_mag), 0);
    en_n = 1'b0;
    repeat (2) @(negedge clk);
    idx_cnt = 0;
    check_all(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule